// File: doc/BRIEF.md
# Dual-Select Static RAM Model

This block is a synthesizable stand-in for an asynchronous byte-wide static RAM. It has two chip selects of opposite polarity (active-low select, active-high enable), an active-low write strobe and an active-low output enable. The parameters give the size: `ADDR_W = 15` gives the full 32,768 x 8 array. The default is a 1,024-entry array, which keeps elaboration small. The bidirectional data bus appears as a separate input bus, an output bus and an output-drive flag. A pad ring can combine these into a real tristate pin.

The device pins change freely between clock edges. The model registers the four controls, the address and the input data on each rising clock edge, and it decodes the registered controls into one of four modes: deselected, write, output-off and read. A write is active while the write strobe is low, the select is low and the enable is high. Any of these three signals may open or close the write. The block keeps the address and data from the last active cycle and stores them when the write condition drops. A read in the same cycle as that store gets the new value through a forwarding path. Read data and the drive flag appear two clock edges after the inputs change.

Top module: `dsel_sram`

## Requirements
- R1: While reset is held and after reset is released with no read issued, `dq_drive` is 0 and `dq_out` is 0. Whenever `dq_drive` is 0, `dq_out` is 0.
- R2: When `sel_n`=0, `enable`=1, `wstb_n`=1 and `oe_n`=0 are applied, then two rising edges later `dq_drive` is 1 and `dq_out` holds the byte stored at `addr`.
- R3: When `oe_n`=1 is applied, then two rising edges later `dq_drive` is 0, whatever the other three controls are.
- R4: When `sel_n`=1 or `enable`=0 is applied, then two rising edges later `dq_drive` is 0. No write takes place, even with `wstb_n`=0.
- R5: When `wstb_n`=0 is applied, then two rising edges later `dq_drive` is 0. A write goes ahead with `oe_n` at either level.
- R6: A write is active in every cycle with `wstb_n`=0, `sel_n`=0 and `enable`=1. The stored location and byte are the `addr` and `din` of the last active cycle. Earlier data applied during the same write is discarded.
- R7: A write is closed by whichever control leaves its active level first: `wstb_n` rising, `sel_n` rising or `enable` falling. Each of the three stores the byte. A write may also be opened by any of the three.
- R8: During consecutive read cycles, each change of `addr` shows up on `dq_out` two rising edges after the change.
- R9: A read applied in the cycle that closes a write to the same address returns the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| sel_n | input | 1 | Active-low chip select |
| enable | input | 1 | Active-high chip enable |
| wstb_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| dq_out | output | DATA_W | Read data, zero while not driving |
| dq_drive | output | 1 | 1 when the data bus is driven by the RAM |

## Verification
Every visible result is due exactly two rising edges after the inputs that cause it: one edge registers the pins and the next registers the read data and drive flag. A store takes effect one edge after the write closes, and the forwarding path hides that edge. The bench drives inputs just after a falling edge. It tags each expected item with the clock count two edges ahead, and the monitor compares that item just after the rising edge whose count matches. A write is judged by a later read of the address, which also follows the two-edge rule.

// File: rtl/dsel_sram_pkg.sv
package dsel_sram_pkg;
  typedef enum logic [1:0] {
    MODE_DESEL  = 2'd0,
    MODE_WRITE  = 2'd1,
    MODE_OUTOFF = 2'd2,
    MODE_READ   = 2'd3
  } sram_mode_e;
endpackage

// File: rtl/dsel_sram_decode.sv
module dsel_sram_decode
  import dsel_sram_pkg::*;
(
  input  logic       sel_n,
  input  logic       enable,
  input  logic       wstb_n,
  input  logic       oe_n,
  output sram_mode_e mode,
  output logic       rd_act,
  output logic       wr_act
);
  // Deselection wins, then the write strobe, then the output enable.
  always_comb begin
    if (sel_n || !enable)  mode = MODE_DESEL;
    else if (!wstb_n)      mode = MODE_WRITE;
    else if (oe_n)         mode = MODE_OUTOFF;
    else                   mode = MODE_READ;
  end

  assign rd_act = (mode == MODE_READ);
  assign wr_act = (mode == MODE_WRITE);
endmodule

// File: rtl/dsel_sram_wtrack.sv
module dsel_sram_wtrack #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_act,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              commit,
  output logic [ADDR_W-1:0] c_addr,
  output logic [DATA_W-1:0] c_data
);
  logic              wr_prev_q, wr_prev_d;
  logic [ADDR_W-1:0] hold_addr_q;
  logic [DATA_W-1:0] hold_data_q;
  logic              hold_en;

  assign hold_en   = wr_act;
  assign wr_prev_d = wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev_q <= 1'b0;
    else        wr_prev_q <= wr_prev_d;
  end

  // Holding registers need no reset: they are read only after an active cycle.
  always_ff @(posedge clk) begin
    if (hold_en) begin
      hold_addr_q <= addr;
      hold_data_q <= din;
    end
  end

  // The store fires in the first cycle the write condition is gone.
  assign commit = wr_prev_q && !wr_act;
  assign c_addr = hold_addr_q;
  assign c_data = hold_data_q;
endmodule

// File: rtl/dsel_sram_array.sv
module dsel_sram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_data,
  input  logic              rd_act,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] q_data,
  output logic              q_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] q_data_d;
  logic              fwd;

  always_ff @(posedge clk) begin
    if (commit) mem[c_addr] <= c_data;
  end

  assign fwd = commit && (c_addr == rd_addr);

  always_comb begin
    q_data_d = '0;
    if (rd_act) q_data_d = fwd ? c_data : mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data <= '0;
      q_en   <= 1'b0;
    end else begin
      q_data <= q_data_d;
      q_en   <= rd_act;
    end
  end
endmodule

// File: rtl/dsel_sram.sv
module dsel_sram
  import dsel_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              sel_n,
  input  logic              enable,
  input  logic              wstb_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_din;
  logic              s_sel_n, s_enable, s_wstb_n, s_oe_n;
  sram_mode_e        mode;
  logic              rd_act, wr_act, commit;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;

  // Pin sampling stage; reset leaves the part deselected.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_addr   <= '0;
      s_din    <= '0;
      s_sel_n  <= 1'b1;
      s_enable <= 1'b0;
      s_wstb_n <= 1'b1;
      s_oe_n   <= 1'b1;
    end else begin
      s_addr   <= addr;
      s_din    <= din;
      s_sel_n  <= sel_n;
      s_enable <= enable;
      s_wstb_n <= wstb_n;
      s_oe_n   <= oe_n;
    end
  end

  dsel_sram_decode u_dec (
    .sel_n  (s_sel_n),
    .enable (s_enable),
    .wstb_n (s_wstb_n),
    .oe_n   (s_oe_n),
    .mode   (mode),
    .rd_act (rd_act),
    .wr_act (wr_act)
  );

  dsel_sram_wtrack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wtrk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_act (wr_act),
    .addr   (s_addr),
    .din    (s_din),
    .commit (commit),
    .c_addr (c_addr),
    .c_data (c_data)
  );

  dsel_sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (commit),
    .c_addr  (c_addr),
    .c_data  (c_data),
    .rd_act  (rd_act),
    .rd_addr (s_addr),
    .q_data  (dq_out),
    .q_en    (dq_drive)
  );
endmodule

// File: rtl/dsel_sram_chk.sv
module dsel_sram_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              enable,
  input logic              wstb_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_drive
);
  logic [1:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_cnt <= 2'd0;
    else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
  end
  assign warm = (warm_cnt == 2'd2);

  p_quiet_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_drive |-> (dq_out == '0));

  p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(!sel_n && enable && wstb_n && !oe_n, 2)) |-> dq_drive);

  p_oe_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(oe_n, 2)) |-> !dq_drive);

  p_desel_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(sel_n || !enable, 2)) |-> !dq_drive);

  p_wstb_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(!wstb_n, 2)) |-> !dq_drive);
endmodule

bind dsel_sram dsel_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sel_n    (sel_n),
  .enable   (enable),
  .wstb_n   (wstb_n),
  .oe_n     (oe_n),
  .dq_out   (dq_out),
  .dq_drive (dq_drive)
);

// File: tb/dsel_sram_tb.sv
module dsel_sram_tb;
  localparam int AW = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          sel_n = 1'b1, enable = 1'b0, wstb_n = 1'b1, oe_n = 1'b1;
  logic [DW-1:0] dq_out;
  logic          dq_drive;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  // Expected-item queue (parallel queues).
  int      q_due[$];
  bit      q_en[$];
  bit      q_chkd[$];
  logic [DW-1:0] q_d[$];
  string   q_tag[$];

  // Reference state, built from R6/R7/R9.
  logic [DW-1:0] ref_mem [1 << AW];
  bit            known   [1 << AW];
  bit            ref_prev = 0;
  logic [AW-1:0] ref_ha;
  logic [DW-1:0] ref_hd;

  always #4 clk = ~clk;

  dsel_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .sel_n(sel_n), .enable(enable), .wstb_n(wstb_n), .oe_n(oe_n),
    .dq_out(dq_out), .dq_drive(dq_drive)
  );

  task automatic drive(input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit csn, input bit cen, input bit wen, input bit oen,
                       input string tag);
    bit wr_now, rd;
    string t;
    @(negedge clk);
    addr = a; din = d; sel_n = csn; enable = cen; wstb_n = wen; oe_n = oen;
    wr_now = !wen && !csn && cen;
    if (ref_prev && !wr_now) begin
      ref_mem[ref_ha] = ref_hd;
      known[ref_ha] = 1;
    end
    if (wr_now) begin
      ref_ha = a;
      ref_hd = d;
    end
    ref_prev = wr_now;
    rd = !csn && cen && wen && !oen;
    t = tag;
    if (t == "") begin
      if (csn || !cen)  t = "R4";
      else if (!wen)    t = "R5";
      else if (oen)     t = "R3";
      else              t = "R2";
    end
    q_due.push_back(cyc + 2);
    q_en.push_back(rd);
    q_chkd.push_back(!rd || known[a]);
    q_d.push_back(rd ? ref_mem[a] : '0);
    q_tag.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive('0, '0, 1'b1, 1'b0, 1'b1, 1'b1, "R4");
  endtask

  // Monitor: compare items whose due count matches, just after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      cyc = cyc + 1;
      #2;
      while (q_due.size() > 0 && q_due[0] <= cyc) begin
        checks++;
        if (dq_drive !== q_en[0]) begin
          errors++;
          $display("FAIL %s: dq_drive=%0b expected %0b (cycle %0d)", q_tag[0], dq_drive, q_en[0], cyc);
        end else if (q_chkd[0] && dq_out !== q_d[0]) begin
          errors++;
          $display("FAIL %s: dq_out=%02h expected %02h (cycle %0d)", q_tag[0], dq_out, q_d[0], cyc);
        end
        void'(q_due.pop_front()); void'(q_en.pop_front()); void'(q_chkd.pop_front());
        void'(q_d.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    checks++;
    if (dq_drive !== 1'b0 || dq_out !== '0) begin
      errors++;
      $display("FAIL R1: drive=%0b out=%02h expected 0/00 in reset", dq_drive, dq_out);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dq_drive !== 1'b0 || dq_out !== '0) begin
      errors++;
      $display("FAIL R1: drive=%0b out=%02h expected 0/00 after reset", dq_drive, dq_out);
    end
    idle(2);

    // R6 + R5: strobe-closed write, data changes mid-write, oe_n low during write
    drive(10'd5, 8'hA1, 0, 1, 0, 0, "R5");
    drive(10'd5, 8'hA2, 0, 1, 0, 0, "R5");
    drive(10'd5, 8'h00, 0, 1, 1, 1, "R3");
    drive(10'd5, 8'h00, 0, 1, 1, 0, "R6");

    // R7: write closed by chip select rising, opened by chip select falling
    drive(10'd9, 8'h3C, 1, 1, 0, 1, "R4");
    drive(10'd9, 8'h3C, 0, 1, 0, 1, "R5");
    drive(10'd9, 8'h3C, 1, 1, 0, 1, "R4");
    // R7: write closed by enable falling
    drive(10'd10, 8'h5A, 0, 1, 0, 1, "R5");
    drive(10'd10, 8'h5A, 0, 0, 0, 1, "R4");
    drive(10'd0, 8'h00, 0, 1, 1, 1, "R3");

    // R8: back-to-back reads with the address changing each cycle
    drive(10'd9,  8'h00, 0, 1, 1, 0, "R7");
    drive(10'd10, 8'h00, 0, 1, 1, 0, "R7");
    drive(10'd5,  8'h00, 0, 1, 1, 0, "R8");
    drive(10'd9,  8'h00, 0, 1, 1, 0, "R8");

    // R4: strobe low while deselected must not store
    drive(10'd5, 8'hFF, 1, 1, 0, 0, "R4");
    drive(10'd5, 8'hFF, 0, 0, 0, 0, "R4");
    drive(10'd5, 8'h00, 0, 1, 1, 0, "R4");

    // R9: read in the cycle that closes the write
    drive(10'd12, 8'h77, 0, 1, 0, 1, "R5");
    drive(10'd12, 8'h00, 0, 1, 1, 0, "R9");
    drive(10'd12, 8'h00, 0, 1, 1, 0, "R9");

    // Every control combination at one address
    for (int c = 0; c < 16; c++)
      drive(10'd5, 8'h10 + c[7:0], c[0], c[1], c[2], c[3], "");
    drive(10'd5, 8'h00, 0, 1, 1, 0, "R6");

    // Pattern fill and readback (R2, R8)
    for (int i = 0; i < 32; i++) begin
      drive(10'(i * 29 + 100), 8'(i * 7 + 3), 0, 1, 0, 1, "R5");
      drive(10'(i * 29 + 100), 8'h00, 0, 1, 1, 1, "R3");
    end
    for (int i = 0; i < 32; i++)
      drive(10'(i * 29 + 100), 8'h00, 0, 1, 1, 0, "R8");
    // Write ended by each control in turn, then read back
    for (int i = 0; i < 12; i++) begin
      drive(10'(i + 600), 8'(8'hC0 ^ i[7:0]), 0, 1, 0, 1, "R7");
      case (i % 3)
        0:       drive(10'(i + 600), 8'h00, 0, 1, 1, 1, "R7");
        1:       drive(10'(i + 600), 8'h00, 1, 1, 0, 1, "R7");
        default: drive(10'(i + 600), 8'h00, 0, 0, 0, 1, "R7");
      endcase
      drive(10'(i + 600), 8'h00, 0, 1, 1, 0, "R7");
    end

    idle(4);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule